// File: doc/BRIEF.md
# Serial Transmitter with Line-Break and Graceful Stop

This block turns parallel words into an asynchronous serial character stream on a single output line. Each character starts with one low start bit, carries either 8 or 9 data bits least significant first, and ends with one high stop bit. Every bit lasts a fixed number of baud ticks, 16 by default. The baud tick comes from outside as a one-cycle strobe. Words arrive on a valid/ready handshake. The line idles high between characters.

Two level-sensitive controls shape the line. The break control pulls the line low in the same cycle it is raised and keeps it low for as long as it stays high. The stop control lets the character in flight finish, then refuses further words. Once the shifter is idle it raises a stopped flag, so that software can assert a break without cutting a character in half. A companion clock output is available for synchronous use. It can run only while a character is shifting, or it can run all the time, and in the second case characters start on a clock-period boundary.

Top module: `uart_brk_tx`

## Requirements
- R1: A character is a 0 start bit, then the data bits least significant first (8 when `cfg_nine` is 0, 9 when it is 1), then a 1 stop bit. Each bit is held for `TICKS_PER_BIT` baud ticks, and `txd` is 1 whenever no character is shifting.
- R2: `in_ready` is 1 only when no character is shifting and `ctl_dis` is 0. A word is taken in any cycle where `in_valid` and `in_ready` are both 1.
- R3: While `ctl_brk` is 1, `txd` is 0 in that same cycle, whatever the shifter is doing. After `ctl_brk` returns to 0 on an idle transmitter, `txd` reads 1.
- R4: Raising `ctl_dis` during a character does not shorten it. While `ctl_dis` stays 1, no word is taken and `busy` stays 0 once the character has ended, even with `in_valid` held at 1.
- R5: `dis_stat` becomes 1 one cycle after a cycle in which `ctl_dis` is 1 and `busy` is 0. It becomes 0 one cycle after `ctl_dis` is 0.
- R6: With `cfg_sync`=1 and `cfg_cont_clk`=0, `sclk` is 0 for the first half of each bit period and 1 for the second half while a character shifts, and 0 when idle.
- R7: With `cfg_sync`=1 and `cfg_cont_clk`=1, `sclk` keeps toggling with the bit-period rhythm while idle. In this mode `in_ready` is 1 only in a cycle whose baud tick completes a bit period, so a character starts on a clock-period boundary.
- R8: With `cfg_sync`=0, `sclk` stays 0.
- R9: `busy` rises the cycle after a word is taken and falls the cycle after the baud tick that completes the stop bit.
- R10: During and right after reset, `txd`=1, `sclk`=0, `busy`=0 and `dis_stat`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_nine | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| cfg_sync | input | 1 | Enables the companion clock output |
| cfg_cont_clk | input | 1 | Makes the companion clock free-running |
| ctl_brk | input | 1 | Level: hold the line at break (low) |
| ctl_dis | input | 1 | Level: stop after the current character |
| baud_tick | input | 1 | One-cycle baud strobe |
| in_data | input | DATA_W | Word to send |
| in_valid | input | 1 | Word on `in_data` is valid |
| in_ready | output | 1 | Transmitter will take a word this cycle |
| txd | output | 1 | Serial data line |
| sclk | output | 1 | Companion serial clock |
| busy | output | 1 | A character is shifting |
| dis_stat | output | 1 | Transmitter has stopped on request |

## Verification
The bench builds the block with `TICKS_PER_BIT`=16 and `DATA_W`=9. With these values it can exercise both character lengths, an 8-tick low/high clock split, and start alignment against a 16-tick clock period. The baud tick fires on two cycles out of three, so bit periods span uneven cycle counts, and the tests land the disable and break requests both inside a character and after it.

// File: rtl/uart_brk_tx_pkg.sv
`timescale 1ns/1ps
package uart_brk_tx_pkg;
    typedef enum logic {
        TX_IDLE  = 1'b0,
        TX_SHIFT = 1'b1
    } tx_phase_e;
endpackage

// File: rtl/uart_brk_tx_timer.sv
`timescale 1ns/1ps
// Sub-bit tick counter: marks the baud tick that completes a bit period.
module uart_brk_tx_timer #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             run,
    input  logic                             clear,
    input  logic                             tick,
    output logic [$clog2(TICKS_PER_BIT)-1:0] cnt,
    output logic                             wrap
);
    localparam int CNT_W = $clog2(TICKS_PER_BIT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_s;

    tmr_s s_d, s_q;

    always_comb begin
        s_d  = s_q;
        wrap = run && tick && (s_q.cnt == LAST);
        if (clear || !run) begin
            s_d.cnt = '0;
        end else if (tick) begin
            s_d.cnt = wrap ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;

    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= LAST);
    p_hold_no_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !clear) |=> $stable(s_q.cnt));
endmodule

// File: rtl/uart_brk_tx_shifter.sv
`timescale 1ns/1ps
// Frame builder and serializer.
module uart_brk_tx_shifter
    import uart_brk_tx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              nine,
    input  logic [DATA_W-1:0] data,
    input  logic              step,
    output logic              busy,
    output logic              serial
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(FRAME_W - 1);
    localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(FRAME_W - 2);

    typedef struct packed {
        tx_phase_e          phase;
        logic               nine;
        logic [IDX_W-1:0]   idx;
        logic [FRAME_W-1:0] shreg;
    } shf_s;

    shf_s s_d, s_q;
    logic last_bit;

    always_comb begin
        s_d      = s_q;
        last_bit = (s_q.idx == (s_q.nine ? LAST_LONG : LAST_SHORT));
        if (load) begin
            s_d.phase = TX_SHIFT;
            s_d.nine  = nine;
            s_d.idx   = '0;
            s_d.shreg = nine ? {1'b1, data, 1'b0}
                             : {2'b11, data[DATA_W-2:0], 1'b0};
        end else if ((s_q.phase == TX_SHIFT) && step) begin
            if (last_bit) begin
                s_d.phase = TX_IDLE;
                s_d.shreg = '1;
            end else begin
                s_d.idx   = s_q.idx + 1'b1;
                s_d.shreg = {1'b1, s_q.shreg[FRAME_W-1:1]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase <= TX_IDLE;
            s_q.nine  <= 1'b0;
            s_q.idx   <= '0;
            s_q.shreg <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy   = (s_q.phase == TX_SHIFT);
    assign serial = s_q.shreg[0];

    p_load_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);
    p_idx_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (s_q.idx <= (s_q.nine ? LAST_LONG : LAST_SHORT)));
    p_stay_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step) |=> busy);
endmodule

// File: rtl/uart_brk_tx_clkgen.sv
`timescale 1ns/1ps
// Companion clock: low for the first half of a bit period, high for the second.
module uart_brk_tx_clkgen #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic                             sync_en,
    input  logic                             run,
    input  logic [$clog2(TICKS_PER_BIT)-1:0] cnt,
    output logic                             sclk
);
    localparam int CNT_W = $clog2(TICKS_PER_BIT);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(TICKS_PER_BIT / 2);

    always_comb begin
        sclk = sync_en && run && (cnt >= HALF);
    end
endmodule

// File: rtl/uart_brk_tx.sv
`timescale 1ns/1ps
module uart_brk_tx #(
    parameter int TICKS_PER_BIT = 16,
    parameter int DATA_W        = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_nine,
    input  logic              cfg_sync,
    input  logic              cfg_cont_clk,
    input  logic              ctl_brk,
    input  logic              ctl_dis,
    input  logic              baud_tick,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              txd,
    output logic              sclk,
    output logic              busy,
    output logic              dis_stat
);
    localparam int CNT_W = $clog2(TICKS_PER_BIT);

    typedef struct packed {
        logic stopped;
    } top_s;

    top_s s_d, s_q;

    logic             free_clk, run, wrap, load, serial;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        free_clk = cfg_sync && cfg_cont_clk;
        run      = busy || free_clk;
        in_ready = !busy && !ctl_dis && (!free_clk || wrap);
        load     = in_valid && in_ready;
        txd      = ctl_brk ? 1'b0 : (busy ? serial : 1'b1);
        s_d         = s_q;
        s_d.stopped = ctl_dis && !busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dis_stat = s_q.stopped;

    uart_brk_tx_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clear (load),
        .tick  (baud_tick),
        .cnt   (cnt),
        .wrap  (wrap)
    );

    uart_brk_tx_shifter #(.DATA_W(DATA_W)) u_shifter (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .nine   (cfg_nine),
        .data   (in_data),
        .step   (wrap),
        .busy   (busy),
        .serial (serial)
    );

    uart_brk_tx_clkgen #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_clkgen (
        .sync_en (cfg_sync),
        .run     (run),
        .cnt     (cnt),
        .sclk    (sclk)
    );

    p_stat_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dis_stat |-> !busy);
    p_stat_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_dis |=> !dis_stat);
    p_start_handshake_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(in_valid) && !$past(ctl_dis)));
    p_cont_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(free_clk)) |-> $past(wrap));
endmodule

// File: tb/uart_brk_tx_test.sv
`timescale 1ns/1ps
module uart_brk_tx_test;
    localparam int TPB = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_nine = 1'b0, cfg_sync = 1'b0, cfg_cont_clk = 1'b0;
    logic       ctl_brk = 1'b0, ctl_dis = 1'b0, baud_tick = 1'b0;
    logic [8:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready, txd, sclk, busy, dis_stat;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    // reference model state
    bit          m_busy = 0, m_dis = 0, m_acc = 0;
    int          m_cnt = 0, m_idx = 0, m_nbits = 10;
    logic [31:0] m_frame = '0;

    always #2.5 clk = ~clk;

    uart_brk_tx #(.TICKS_PER_BIT(TPB), .DATA_W(9)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_nine(cfg_nine), .cfg_sync(cfg_sync),
        .cfg_cont_clk(cfg_cont_clk), .ctl_brk(ctl_brk), .ctl_dis(ctl_dis),
        .baud_tick(baud_tick), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .txd(txd), .sclk(sclk), .busy(busy),
        .dis_stat(dis_stat)
    );

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // One clock: drive tick, compare all outputs to the model, advance the model.
    task automatic step();
        bit free, run, wrap, e_ready, e_txd, e_sclk, nxt_dis;
        baud_tick = ((cyc % 3) != 2);
        #1;
        free    = cfg_sync && cfg_cont_clk;
        run     = m_busy || free;
        wrap    = run && baud_tick && (m_cnt == TPB - 1);
        e_ready = !m_busy && !ctl_dis && (!free || wrap);
        e_txd   = ctl_brk ? 1'b0 : (m_busy ? m_frame[m_idx] : 1'b1);
        e_sclk  = cfg_sync && run && (m_cnt >= TPB / 2);
        cmp("R2 in_ready", in_ready, e_ready);
        cmp("R1/R3 txd", txd, e_txd);
        cmp("R6/R7/R8 sclk", sclk, e_sclk);
        cmp("R9 busy", busy, m_busy);
        cmp("R5 dis_stat", dis_stat, m_dis);
        m_acc   = in_valid && e_ready;
        nxt_dis = ctl_dis && !m_busy;
        if (m_acc) begin
            m_busy = 1; m_idx = 0; m_cnt = 0;
            if (cfg_nine) begin
                m_frame = 32'h400 | (32'(in_data) << 1); m_nbits = 11;
            end else begin
                m_frame = 32'h200 | (32'(in_data[7:0]) << 1); m_nbits = 10;
            end
        end else if (!run) begin
            m_cnt = 0;
        end else if (baud_tick) begin
            if (wrap) begin
                m_cnt = 0;
                if (m_busy) begin
                    if (m_idx == m_nbits - 1) m_busy = 0;
                    else m_idx++;
                end
            end else begin
                m_cnt++;
            end
        end
        m_dis = nxt_dis;
        @(posedge clk);
        @(negedge clk);
        cyc++;
    endtask

    task automatic send(input logic [8:0] d);
        in_data = d; in_valid = 1;
        for (int i = 0; i < 400; i++) begin
            step();
            if (m_acc) break;
        end
        in_valid = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            if (!m_busy) break;
            step();
        end
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        int hi, lo;
        @(negedge clk);
        // R10: reset values
        cmp("R10 txd in reset", txd, 1); cmp("R10 sclk in reset", sclk, 0);
        cmp("R10 busy in reset", busy, 0); cmp("R10 dis_stat in reset", dis_stat, 0);
        @(negedge clk);
        rst_n = 1;
        run_cycles(3);

        // R1: 8-bit async characters
        send(9'h0A5); wait_idle();
        send(9'h13C); wait_idle();   // bit 8 ignored in 8-bit mode
        run_cycles(5);
        // R1: 9-bit character
        cfg_nine = 1;
        send(9'h1F0); wait_idle();
        send(9'h003); wait_idle();
        cfg_nine = 0;

        // R4: disable mid-character
        send(9'h055);
        run_cycles(60);
        ctl_dis = 1;
        step();
        cmp("R4 character continues after disable", busy, 1);
        wait_idle();
        run_cycles(2);
        cmp("R5 stopped flag set", dis_stat, 1);
        in_data = 9'h0FF; in_valid = 1;
        run_cycles(100);
        cmp("R4 no word taken while disabled", busy, 0);
        cmp("R4 ready low while disabled", in_ready, 0);
        in_valid = 0;

        // R3: break after stop sequence
        ctl_brk = 1;
        step();
        cmp("R3 break drives low", txd, 0);
        run_cycles(40);
        cmp("R3 break holds low", txd, 0);
        ctl_brk = 0;
        step();
        cmp("R3 line idle high after break", txd, 1);
        ctl_dis = 0;
        step();
        cmp("R5 stopped flag cleared", dis_stat, 0);

        // R3: break forced during a character
        send(9'h0FF);
        run_cycles(30);
        ctl_brk = 1;
        step();
        cmp("R3 break overrides character", txd, 0);
        ctl_brk = 0;
        wait_idle();

        // R8: async, sclk stays low during a character
        hi = 0;
        send(9'h0C3);
        for (int i = 0; i < 300; i++) begin if (sclk) hi++; step(); end
        cmp("R8 sclk silent in async mode", hi, 0);
        wait_idle();

        // R6: gated sync clock
        cfg_sync = 1;
        send(9'h05A); wait_idle();
        hi = 0;
        for (int i = 0; i < 60; i++) begin if (sclk) hi++; step(); end
        cmp("R6 sclk quiet when idle", hi, 0);

        // R7: continuous sync clock
        cfg_cont_clk = 1;
        hi = 0; lo = 0;
        for (int i = 0; i < 200; i++) begin if (sclk) hi++; else lo++; step(); end
        cmp("R7 sclk runs while idle", (hi > 0) && (lo > 0), 1);
        send(9'h0E7); wait_idle();
        cfg_nine = 1;
        send(9'h1AA); wait_idle();
        run_cycles(50);
        cfg_cont_clk = 0; cfg_sync = 0; cfg_nine = 0;
        run_cycles(5);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule